// File: doc/BRIEF.md
# Header Word Serializer

This block builds a packet header out of a set of fields and sends it as a short framed burst of data-width words. Each field comes from one of two places. One is a wide vector driven by the data path. The other is a bank of 32-bit registers written over a simple write-only port. A mask fixed at build time gives one select bit per field and picks the source. The merged vector is always visible on a parallel output. It is also captured when the payload's start-of-packet is offered. From the following cycle it is streamed out most significant word first, with valid, sop, eop and ready handshaking.

The block sits in front of a packet concatenation stage. It is intended for framing, for example an Ethernet, IPv4 and UDP header followed by a sequence number. Field widths, field count, output word width and the register reset contents are all parameters. When the header fits into one output word, a build-time variant sends a single beat that carries sop and eop together. A header wider than the configured maximum stream width is rejected at elaboration.

Top module: `hdr_word_serializer`

## Requirements
- R1: After reset, hw_valid_o is 0 and sop_ready_o is 1. The registers hold the FIELD_DEFAULTS value, so a register-sourced field on fld_merged_o shows its default.
- R2: For field f, fld_merged_o carries the register bits when FIELD_SEL[f] is 1 and the fld_dp_i bits when it is 0. The output is combinational. Fields are packed from bit 0 upward in index order, with the width of field f in bits [16f+15:16f] of FIELD_WIDTHS.
- R3: A capture happens on a clock edge where sop_valid_i and sop_ready_o are both 1. hw_valid_o rises on the next cycle. The first word is the top DATA_W bits of the captured header, and each following word holds the next lower DATA_W bits.
- R4: One header is sent as exactly ceil(HDR_W/DATA_W) accepted words. hw_sop_o is set on the first word only, hw_eop_o on the last word only, and hw_valid_o stays high throughout.
- R5: When HDR_W is not a multiple of DATA_W, the low (NUM_WORDS*DATA_W - HDR_W) bits of the last word are 0.
- R6: While hw_valid_o is 1 and hw_ready_i is 0, hw_data_o, hw_sop_o and hw_eop_o hold their values into the next cycle.
- R7: sop_ready_o is 0 from the capture edge until the edge on which the eop word is accepted. A sop_valid_i while sop_ready_o is 0 starts nothing.
- R8: A write of cfg_wdata_i at address k sets register bits [32k+31:32k] of the header vector, where bit j of the data goes to header bit 32k+j. A write to an address at or above ceil(HDR_W/32) changes nothing.
- R9: When HDR_W <= DATA_W, each header is sent as one word with valid, sop and eop all 1. The header sits in the top bits of that word and the low bits are 0.
- R10: Changes to fld_dp_i or to the registers after a capture do not alter the words of the header being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | REG_AW (2) | Register word address, least significant word at 0 |
| cfg_wdata_i | input | 32 | Register write data |
| sop_valid_i | input | 1 | Payload start-of-packet offered; header fields are valid |
| sop_ready_o | output | 1 | High when a new header may be captured |
| fld_dp_i | input | HDR_W (76) | Data-path field vector |
| fld_merged_o | output | HDR_W (76) | Merged field vector after per-field source selection |
| hw_valid_o | output | 1 | Header word valid |
| hw_sop_o | output | 1 | First header word |
| hw_eop_o | output | 1 | Last header word |
| hw_data_o | output | DATA_W (32) | Header word |
| hw_ready_i | input | 1 | Downstream accepts the word |

## Verification
The bench builds the default configuration: four fields of 16, 8, 40 and 12 bits, making 76 header bits. Fields 0 and 2 are taken from the registers, so both sources and a register word that spans two fields are exercised. The 32-bit output width gives three words per header with 20 pad bits, which brings the multi-word framing, the zero padding and mid-packet stalls within reach. A second copy built with a 128-bit output width takes the single-beat variant. Both copies run under random ready, random offers during busy periods and register writes, including writes to the unused third address code.

// File: rtl/hdr_ser_pkg.sv
package hdr_ser_pkg;

   // Field widths are packed as 16-bit slots, slot 0 in the low bits.
   localparam int MAX_FIELDS = 64;
   localparam int WSLOT      = 16;

   typedef logic [MAX_FIELDS*WSLOT-1:0] width_list_t;

   typedef enum logic {
      SH_IDLE = 1'b0,
      SH_SEND = 1'b1
   } sh_state_t;

   function automatic int fld_width(width_list_t lst, int idx);
      return int'(lst[idx*WSLOT +: WSLOT]);
   endfunction

   // Lowest header bit of field idx (sum of widths of all lower fields).
   function automatic int fld_lo(width_list_t lst, int idx);
      int acc;
      acc = 0;
      for (int i = 0; i < idx; i++) begin
         acc += fld_width(lst, i);
      end
      return acc;
   endfunction

   function automatic int ceil_div(int num, int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int clog2_min1(int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/hdr_field_merge.sv
module hdr_field_merge
   import hdr_ser_pkg::*;
#(
   parameter int                    NUM_FIELDS = 4,
   parameter width_list_t           WIDTHS     = '0,
   parameter logic [NUM_FIELDS-1:0] SEL        = '0,
   parameter int                    HDR_W      = 1
)(
   input  logic [HDR_W-1:0] dp_i,
   input  logic [HDR_W-1:0] reg_i,
   output logic [HDR_W-1:0] merged_o
);

   // One source choice per field, fixed at build time.
   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
      localparam int LO = fld_lo(WIDTHS, f);
      localparam int W  = fld_width(WIDTHS, f);
      if (SEL[f]) begin : g_from_reg
         logic unused_dp_bits;
         assign merged_o[LO +: W] = reg_i[LO +: W];
         assign unused_dp_bits    = ^dp_i[LO +: W];
      end else begin : g_from_dp
         logic unused_reg_bits;
         assign merged_o[LO +: W] = dp_i[LO +: W];
         assign unused_reg_bits   = ^reg_i[LO +: W];
      end
   end

endmodule

// File: rtl/hdr_reg_bank.sv
module hdr_reg_bank #(
   parameter int               HDR_W   = 32,
   parameter int               REG_AW  = 1,
   parameter logic [HDR_W-1:0] RST_VAL = '0
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_i,
   input  logic [REG_AW-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [HDR_W-1:0]  vec_o
);

   logic [HDR_W-1:0] store;

   // Header bit b lives in word b/32 at lane b%32; addresses past the
   // last word match no bit and so are dropped.
   always_ff @(posedge clk) begin
      if (rst) begin
         store <= RST_VAL;
      end else if (wr_i) begin
         for (int b = 0; b < HDR_W; b++) begin
            if (addr_i == REG_AW'(b / 32)) begin
               store[b] <= wdata_i[b % 32];
            end
         end
      end
   end

   assign vec_o = store;

endmodule

// File: rtl/hdr_word_shifter.sv
module hdr_word_shifter
   import hdr_ser_pkg::*;
#(
   parameter int HDR_W     = 64,
   parameter int DATA_W    = 32,
   parameter int NUM_WORDS = 2,
   parameter int CNT_W     = 1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic [HDR_W-1:0]  hdr_i,
   output logic              busy_o,
   input  logic              ready_i,
   output logic              valid_o,
   output logic              sop_o,
   output logic              eop_o,
   output logic [DATA_W-1:0] data_o
);

   localparam int TOT_W = NUM_WORDS * DATA_W;
   localparam int PAD_W = TOT_W - HDR_W;

   logic [TOT_W-1:0] padded;

   // Header aligned to the top; pad only exists for uneven widths.
   if (PAD_W == 0) begin : g_nopad
      assign padded = hdr_i;
   end else begin : g_pad
      assign padded = {hdr_i, {PAD_W{1'b0}}};
   end

   if (NUM_WORDS == 1) begin : g_single
      logic              busy;
      logic [DATA_W-1:0] word;

      always_ff @(posedge clk) begin
         if (rst) begin
            busy <= 1'b0;
            word <= '0;
         end else if (!busy) begin
            if (load_i) begin
               busy <= 1'b1;
               word <= padded;
            end
         end else if (ready_i) begin
            busy <= 1'b0;
         end
      end

      assign busy_o  = busy;
      assign valid_o = busy;
      assign sop_o   = busy;
      assign eop_o   = busy;
      assign data_o  = word;
   end else begin : g_multi
      localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_WORDS - 1);

      sh_state_t        state;
      logic [CNT_W-1:0] cnt;
      logic [TOT_W-1:0] shreg;

      always_ff @(posedge clk) begin
         if (rst) begin
            state <= SH_IDLE;
            cnt   <= '0;
            shreg <= '0;
         end else begin
            case (state)
               SH_IDLE: begin
                  if (load_i) begin
                     state <= SH_SEND;
                     cnt   <= '0;
                     shreg <= padded;
                  end
               end
               SH_SEND: begin
                  if (ready_i) begin
                     if (cnt == LAST) begin
                        state <= SH_IDLE;
                        cnt   <= '0;
                     end else begin
                        cnt   <= cnt + 1'b1;
                        shreg <= shreg << DATA_W;
                     end
                  end
               end
               default: state <= SH_IDLE;
            endcase
         end
      end

      assign busy_o  = (state == SH_SEND);
      assign valid_o = busy_o;
      assign sop_o   = busy_o && (cnt == '0);
      assign eop_o   = busy_o && (cnt == LAST);
      assign data_o  = shreg[TOT_W-1 -: DATA_W];
   end

endmodule

// File: rtl/hdr_word_serializer.sv
module hdr_word_serializer
   import hdr_ser_pkg::*;
#(
   parameter int                            DATA_W         = 32,
   parameter int                            NUM_FIELDS     = 4,
   parameter logic [NUM_FIELDS*WSLOT-1:0]   FIELD_WIDTHS   = {16'd12, 16'd40, 16'd8, 16'd16},
   parameter logic [NUM_FIELDS-1:0]         FIELD_SEL      = 4'b0101,
   parameter int                            MAX_HDR_W      = 1024,
   parameter logic [MAX_HDR_W-1:0]          FIELD_DEFAULTS = MAX_HDR_W'(76'hBEE123456789A3CA5C3),
   localparam int HDR_W     = fld_lo(width_list_t'(FIELD_WIDTHS), NUM_FIELDS),
   localparam int NUM_WORDS = ceil_div(HDR_W, DATA_W),
   localparam int REG_WORDS = ceil_div(HDR_W, 32),
   localparam int REG_AW    = clog2_min1(REG_WORDS),
   localparam int CNT_W     = clog2_min1(NUM_WORDS)
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_wr_i,
   input  logic [REG_AW-1:0] cfg_addr_i,
   input  logic [31:0]       cfg_wdata_i,
   input  logic              sop_valid_i,
   output logic              sop_ready_o,
   input  logic [HDR_W-1:0]  fld_dp_i,
   output logic [HDR_W-1:0]  fld_merged_o,
   output logic              hw_valid_o,
   output logic              hw_sop_o,
   output logic              hw_eop_o,
   output logic [DATA_W-1:0] hw_data_o,
   input  logic              hw_ready_i
);

   localparam width_list_t WLIST = width_list_t'(FIELD_WIDTHS);

   // Build-time legality checks.
   if (NUM_FIELDS < 1 || NUM_FIELDS > MAX_FIELDS) begin : g_bad_nfields
      $error("hdr_word_serializer: NUM_FIELDS out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("hdr_word_serializer: DATA_W must be positive");
   end
   if (HDR_W > MAX_HDR_W) begin : g_bad_hdr_w
      $error("hdr_word_serializer: header wider than maximum stream width");
   end
   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_chk_w
      if (fld_width(WLIST, f) == 0) begin : g_zero
         $error("hdr_word_serializer: zero-width field");
      end
   end

   logic [HDR_W-1:0] reg_vec;
   logic             sh_busy;

   hdr_reg_bank #(
      .HDR_W   (HDR_W),
      .REG_AW  (REG_AW),
      .RST_VAL (FIELD_DEFAULTS[HDR_W-1:0])
   ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_i    (cfg_wr_i),
      .addr_i  (cfg_addr_i),
      .wdata_i (cfg_wdata_i),
      .vec_o   (reg_vec)
   );

   hdr_field_merge #(
      .NUM_FIELDS (NUM_FIELDS),
      .WIDTHS     (WLIST),
      .SEL        (FIELD_SEL),
      .HDR_W      (HDR_W)
   ) u_merge (
      .dp_i     (fld_dp_i),
      .reg_i    (reg_vec),
      .merged_o (fld_merged_o)
   );

   hdr_word_shifter #(
      .HDR_W     (HDR_W),
      .DATA_W    (DATA_W),
      .NUM_WORDS (NUM_WORDS),
      .CNT_W     (CNT_W)
   ) u_shift (
      .clk     (clk),
      .rst     (rst),
      .load_i  (sop_valid_i),
      .hdr_i   (fld_merged_o),
      .busy_o  (sh_busy),
      .ready_i (hw_ready_i),
      .valid_o (hw_valid_o),
      .sop_o   (hw_sop_o),
      .eop_o   (hw_eop_o),
      .data_o  (hw_data_o)
   );

   assign sop_ready_o = ~sh_busy;

endmodule

// File: rtl/hdr_word_serializer_chk.sv
module hdr_word_serializer_chk #(
   parameter int DATA_W    = 32,
   parameter int NUM_WORDS = 1
)(
   input logic              clk,
   input logic              rst,
   input logic              sop_valid_i,
   input logic              sop_ready_o,
   input logic              hw_valid_o,
   input logic              hw_sop_o,
   input logic              hw_eop_o,
   input logic [DATA_W-1:0] hw_data_o,
   input logic              hw_ready_i
);

   int unsigned beat_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         beat_cnt <= 0;
      end else if (hw_valid_o && hw_ready_i) begin
         beat_cnt <= hw_eop_o ? 0 : beat_cnt + 1;
      end
   end

   // R6
   hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
      hw_valid_o && !hw_ready_i |=> hw_valid_o && $stable(hw_data_o)
                                    && $stable(hw_sop_o) && $stable(hw_eop_o));

   // R7
   busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
      hw_valid_o |-> !sop_ready_o);

   // R7
   reopen_chk: assert property (@(posedge clk) disable iff (rst)
      hw_valid_o && hw_eop_o && hw_ready_i |=> sop_ready_o && !hw_valid_o);

   // R3
   start_chk: assert property (@(posedge clk) disable iff (rst)
      sop_valid_i && sop_ready_o |=> hw_valid_o && hw_sop_o);

   // R4
   frame_len_chk: assert property (@(posedge clk) disable iff (rst)
      hw_valid_o && hw_eop_o |-> beat_cnt == 32'(NUM_WORDS - 1));

   // R4
   sop_first_chk: assert property (@(posedge clk) disable iff (rst)
      hw_valid_o && hw_sop_o |-> beat_cnt == 0);

endmodule

bind hdr_word_serializer hdr_word_serializer_chk #(
   .DATA_W    (DATA_W),
   .NUM_WORDS (NUM_WORDS)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .sop_valid_i (sop_valid_i),
   .sop_ready_o (sop_ready_o),
   .hw_valid_o  (hw_valid_o),
   .hw_sop_o    (hw_sop_o),
   .hw_eop_o    (hw_eop_o),
   .hw_data_o   (hw_data_o),
   .hw_ready_i  (hw_ready_i)
);

// File: tb/tb_hdr_word_serializer.sv
module tb_hdr_word_serializer;

   localparam int HW  = 76;
   localparam int DW  = 32;
   localparam int DWB = 128;
   localparam logic [75:0] DEF  = 76'hBEE123456789A3CA5C3;
   // Register-sourced bits: field 0 [15:0] and field 2 [63:24].
   localparam logic [75:0] MASK = 76'h000FFFFFFFFFF00FFFF;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_wr = 1'b0;
   logic [1:0]    cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          sop_valid = 1'b0;
   logic [HW-1:0] fld_dp = '0;
   logic          hw_ready = 1'b1;
   logic          b_ready = 1'b1;

   logic          sop_ready, hw_valid, hw_sop, hw_eop;
   logic [DW-1:0] hw_data;
   logic [HW-1:0] merged;
   logic          b_sop_ready, b_valid, b_sop, b_eop;
   logic [DWB-1:0] b_data;
   logic [HW-1:0] b_merged;

   always #10 clk = ~clk;

   hdr_word_serializer dut (
      .clk(clk), .rst(rst), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
      .cfg_wdata_i(cfg_wdata), .sop_valid_i(sop_valid), .sop_ready_o(sop_ready),
      .fld_dp_i(fld_dp), .fld_merged_o(merged), .hw_valid_o(hw_valid),
      .hw_sop_o(hw_sop), .hw_eop_o(hw_eop), .hw_data_o(hw_data),
      .hw_ready_i(hw_ready));

   hdr_word_serializer #(.DATA_W(DWB)) dut_w (
      .clk(clk), .rst(rst), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
      .cfg_wdata_i(cfg_wdata), .sop_valid_i(sop_valid), .sop_ready_o(b_sop_ready),
      .fld_dp_i(fld_dp), .fld_merged_o(b_merged), .hw_valid_o(b_valid),
      .hw_sop_o(b_sop), .hw_eop_o(b_eop), .hw_data_o(b_data),
      .hw_ready_i(b_ready));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [31:0]  m_regs [3];
   logic [31:0]  m_q [$];
   int           m_sent;
   bit           b_busy;
   logic [127:0] b_word;
   logic [95:0]  m_pad;

   function automatic logic [75:0] m_merged();
      logic [95:0] rv;
      rv = {m_regs[2], m_regs[1], m_regs[0]};
      return (rv[75:0] & MASK) | (fld_dp & ~MASK);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_regs[0] = DEF[31:0];
         m_regs[1] = DEF[63:32];
         m_regs[2] = {20'h0, DEF[75:64]};
         m_q.delete();
         m_sent = 0;
         b_busy = 1'b0;
         b_word = '0;
      end else begin
         if (m_q.size() != 0) begin
            if (hw_ready) begin
               void'(m_q.pop_front());
               m_sent++;
            end
         end else if (sop_valid) begin
            m_pad = {m_merged(), 20'h0};
            m_q.push_back(m_pad[95:64]);
            m_q.push_back(m_pad[63:32]);
            m_q.push_back(m_pad[31:0]);
            m_sent = 0;
         end
         if (b_busy) begin
            if (b_ready) b_busy = 1'b0;
         end else if (sop_valid) begin
            b_busy = 1'b1;
            b_word = {m_merged(), 52'h0};
         end
         if (cfg_wr && cfg_addr < 2'd3) m_regs[cfg_addr] = cfg_wdata;
      end
   end

   // ---------------- per-cycle comparison ----------------
   bit          stall_prev = 1'b0;
   logic [31:0] data_prev;

   always @(negedge clk) begin
      if (!rst && !done) begin
         chk(hw_valid == (m_q.size() != 0), "R4", "valid",
             128'(hw_valid), 128'(m_q.size() != 0));
         chk(sop_ready == (m_q.size() == 0), "R7", "sop_ready",
             128'(sop_ready), 128'(m_q.size() == 0));
         chk(merged == m_merged(), "R2", "merged", 128'(merged), 128'(m_merged()));
         if (m_q.size() != 0) begin
            chk(hw_data == m_q[0], "R3", "word", 128'(hw_data), 128'(m_q[0]));
            chk(hw_sop == (m_sent == 0), "R4", "sop", 128'(hw_sop), 128'(m_sent == 0));
            chk(hw_eop == (m_q.size() == 1), "R4", "eop",
                128'(hw_eop), 128'(m_q.size() == 1));
            if (m_q.size() == 1)
               chk(hw_data[19:0] == 20'h0, "R5", "pad bits", 128'(hw_data[19:0]), 128'(0));
         end
         if (stall_prev)
            chk(hw_data == data_prev, "R6", "held word", 128'(hw_data), 128'(data_prev));
         stall_prev = hw_valid && !hw_ready;
         data_prev  = hw_data;
         // single-word copy
         chk(b_valid == b_busy, "R9", "wide valid", 128'(b_valid), 128'(b_busy));
         chk(b_sop_ready == !b_busy, "R9", "wide ready", 128'(b_sop_ready), 128'(!b_busy));
         if (b_busy) begin
            chk(b_sop && b_eop, "R9", "wide sop+eop", 128'({b_sop, b_eop}), 128'(3));
            chk(b_data == b_word, "R9", "wide word", b_data, b_word);
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   logic [31:0] held_word;

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      // R1
      chk(sop_ready && !hw_valid, "R1", "idle after reset",
          128'({sop_ready, hw_valid}), 128'(2));
      chk(merged == (DEF & MASK), "R1", "defaults", 128'(merged), 128'(DEF & MASK));

      // basic header
      step();
      fld_dp = 76'hF0E1D2C3B4A596877;
      sop_valid = 1'b1;
      step();
      sop_valid = 1'b0;
      repeat (5) step();

      // R10/R7: capture under stall, then disturb inputs while busy
      fld_dp = 76'h123456789ABCDEF0123;
      sop_valid = 1'b1;
      hw_ready = 1'b0;
      step();
      @(negedge clk);
      held_word = hw_data;
      step();
      fld_dp = 76'hFFFFFFFFFFFFFFFFFFF;
      cfg_wr = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'h0BADF00D;
      step();
      cfg_wr = 1'b0;
      @(negedge clk);
      // R10
      chk(hw_data == held_word && hw_sop, "R10", "word in flight",
          128'(hw_data), 128'(held_word));
      // R7
      chk(!sop_ready, "R7", "blocked while busy", 128'(sop_ready), 128'(0));
      repeat (4) begin step(); hw_ready = ~hw_ready; end
      hw_ready = 1'b1;
      sop_valid = 1'b0;
      repeat (8) step();

      // R8: register words
      fld_dp = '0;
      cfg_wr = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'h12345678;
      step();
      cfg_addr = 2'd1; cfg_wdata = 32'hCAFEF00D;
      step();
      cfg_wr = 1'b0;
      @(negedge clk);
      chk(merged[15:0] == 16'h5678, "R8", "word0 field0", 128'(merged[15:0]), 128'(16'h5678));
      chk(merged[63:32] == 32'hCAFEF00D, "R8", "word1", 128'(merged[63:32]), 128'(32'hCAFEF00D));
      chk(merged[23:16] == 8'h00, "R8", "dp field kept", 128'(merged[23:16]), 128'(0));
      step();
      cfg_wr = 1'b1; cfg_addr = 2'd3; cfg_wdata = 32'hFFFFFFFF;
      step();
      cfg_wr = 1'b0;
      @(negedge clk);
      chk(merged[63:0] == {32'hCAFEF00D, 8'h12, 8'h00, 16'h5678}, "R8", "addr 3 ignored",
          128'(merged[63:0]), 128'({32'hCAFEF00D, 8'h12, 8'h00, 16'h5678}));

      // random traffic
      for (int i = 0; i < 600; i++) begin
         logic [95:0] r;
         step();
         r = {$urandom(), $urandom(), $urandom()};
         fld_dp    = r[75:0];
         sop_valid = ($urandom() % 3) == 0;
         hw_ready  = ($urandom() % 4) != 0;
         b_ready   = ($urandom() % 2) == 0;
         cfg_wr    = ($urandom() % 5) == 0;
         cfg_addr  = 2'($urandom());
         cfg_wdata = $urandom();
      end
      step();
      sop_valid = 1'b0; cfg_wr = 1'b0; hw_ready = 1'b1; b_ready = 1'b1;
      repeat (10) step();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not end actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule